// File: doc/BRIEF.md
# Lockable Register-Mapped Watchdog Timer

This block is a watchdog timer peripheral with a word-addressed register port. Software loads a reload value, sets the run bit, and the counter counts down by one on each clock. When the count reaches zero, the next clock reloads it and raises a timeout status bit. If software does not clear that status before the following expiry, and reset requests are allowed, the block pulses a reset request for one cycle.

Configuration is protected by a write lock. Any write to the lock register other than the unlock key freezes the load, control and stall registers. Writing the load register while the timer runs replaces the count at once. A zero reload value raises the timeout status immediately. A stall bit lets the counter hold its value while an external debug-halt input is high.

Register map, by word offset in the low three bits of the address (an address with any higher bit set is unmapped): 0 reload, 1 current count, 2 control (bit 0 run, bit 1 reset-request enable), 3 timeout clear (bit 0), 4 raw status (bit 0), 5 masked status (bit 0), 6 debug stall (bit 0), 7 lock. Writes take effect on the clock edge. Reads are combinational from `rd_addr`.

Top module: `wdog_lockable`

## Requirements
- R1: After reset the reload and count registers read all ones, control, raw status, stall and lock (unlocked, 0) read zero, and `irq` and `rst_req` are low.
- R2: Writing 1 to control bit 0 (offset 2) loads the count from the reload register on that edge and starts counting. The bit reads back as 1, and writing 0 to it does not clear it; only reset does.
- R3: While running, the count falls by one per clock. On the edge where it is zero it reloads and sets raw status bit 0 (offset 4), so with reload L the first timeout comes L+1 edges after the run write.
- R4: Masked status bit 0 (offset 5) and `irq` equal raw status AND the run bit. Raw status is visible while stopped.
- R5: Writing bit 0 of offset 3 clears the raw status. If an expiry falls on the same edge, the status stays set.
- R6: An expiry while raw status is already set and control bit 1 is 1 pulses `rst_req` high for exactly one cycle. An expiry with the status clear gives no pulse.
- R7: A write to offset 7 of any value other than the key (default 32'h1ACC_E55E) locks the block. Offset 7 then reads 1, and writes to offsets 0, 2 and 6 change nothing.
- R8: Writing the key to offset 7 unlocks the block. Offset 7 reads 0 and configuration writes take effect again.
- R9: An unlocked write to the reload register while running copies the value into the count on the same edge.
- R10: An unlocked write of zero to the reload register sets raw status on that edge.
- R11: With stall bit 0 (offset 6) set and `dbg_halt` high, the count holds. With the stall bit clear, the count keeps running whatever `dbg_halt` is.
- R12: Offset 1 returns the live count, and every unmapped address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Read data, combinational |
| dbg_halt | input | 1 | Processor halted for debug |
| irq | output | 1 | Timeout interrupt |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The assertions assume that `wr_en`, `wr_addr` and `wr_data` are stable around the clock edge, that only one register is written per cycle, and that `dbg_halt` is a level with no meaning on the edge itself. The bench drives every input on the falling edge and holds it for a whole cycle, so each write lands on exactly one rising edge. It sweeps reload values 1 to 8 with a reset between runs, which keeps every expected count small enough to compute as a plain difference from the edge of the run write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int OFS_W = 3;

  typedef enum logic [OFS_W-1:0] {
    OFS_RELOAD = 3'd0,
    OFS_COUNT  = 3'd1,
    OFS_CTRL   = 3'd2,
    OFS_CLEAR  = 3'd3,
    OFS_RAW    = 3'd4,
    OFS_MASKED = 3'd5,
    OFS_STALL  = 3'd6,
    OFS_LOCK   = 3'd7
  } wdog_ofs_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_RST_BIT = 1;

endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg
  import wdog_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = 32'h1ACC_E55E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_mapped,
  input  wdog_ofs_e         wr_ofs,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] reload_q,
  output logic              run_q,
  output logic              rst_en_q,
  output logic              stall_q,
  output logic              locked_q,
  output logic              reload_wr,
  output logic              run_start
);

  logic wr_hit, cfg_ok, ctrl_wr, stall_wr, lock_wr;
  logic run_d, rst_en_d, stall_d, locked_d;
  logic [DATA_W-1:0] reload_d;

  always_comb begin
    wr_hit    = wr_en && wr_mapped;
    cfg_ok    = wr_hit && !locked_q;
    reload_wr = cfg_ok && (wr_ofs == OFS_RELOAD);
    ctrl_wr   = cfg_ok && (wr_ofs == OFS_CTRL);
    stall_wr  = cfg_ok && (wr_ofs == OFS_STALL);
    lock_wr   = wr_hit && (wr_ofs == OFS_LOCK);
    run_start = ctrl_wr && wr_data[CTRL_RUN_BIT] && !run_q;
    reload_d  = wr_data;
    run_d     = run_q | wr_data[CTRL_RUN_BIT];
    rst_en_d  = wr_data[CTRL_RST_BIT];
    stall_d   = wr_data[0];
    locked_d  = (wr_data != KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '1;
      run_q    <= 1'b0;
      rst_en_q <= 1'b0;
      stall_q  <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      if (reload_wr) reload_q <= reload_d;
      if (ctrl_wr) begin
        run_q    <= run_d;
        rst_en_q <= rst_en_d;
      end
      if (stall_wr) stall_q  <= stall_d;
      if (lock_wr)  locked_q <= locked_d;
    end
  end

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              stall,
  input  logic              dbg_halt,
  input  logic [DATA_W-1:0] reload,
  input  logic              reload_wr,
  input  logic              run_start,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] count_q,
  output logic              expire
);

  logic              frozen, advance, cnt_en;
  logic [DATA_W-1:0] count_d;

  always_comb begin
    frozen  = stall && dbg_halt;
    advance = run && !frozen && !reload_wr;
    expire  = advance && (count_q == '0);
    cnt_en  = run_start || (reload_wr && run) || advance;
    if (reload_wr)
      count_d = wr_data;
    else if (run_start || expire)
      count_d = reload;
    else
      count_d = count_q - DATA_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '1;
    else if (cnt_en) count_q <= count_d;
  end

endmodule

// File: rtl/wdog_status.sv
module wdog_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic zero_load,
  input  logic clear_wr,
  input  logic rst_en,
  output logic raw_q,
  output logic rst_req_q
);

  logic raw_set, raw_d, raw_en, rst_req_d;

  always_comb begin
    raw_set   = expire || zero_load;
    raw_en    = raw_set || clear_wr;
    raw_d     = raw_set;
    rst_req_d = expire && raw_q && rst_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (raw_en) raw_q <= raw_d;
      rst_req_q <= rst_req_d;
    end
  end

endmodule

// File: rtl/wdog_rdmux.sv
module wdog_rdmux
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              rd_mapped,
  input  wdog_ofs_e         rd_ofs,
  input  logic [DATA_W-1:0] reload,
  input  logic [DATA_W-1:0] count,
  input  logic              run,
  input  logic              rst_en,
  input  logic              raw,
  input  logic              stall,
  input  logic              locked,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [DATA_W-1:0] LOCKED_CODE = DATA_W'(1);

  always_comb begin
    rd_data = '0;
    if (rd_mapped) begin
      case (rd_ofs)
        OFS_RELOAD: rd_data = reload;
        OFS_COUNT:  rd_data = count;
        OFS_CTRL:   rd_data = {{(DATA_W-2){1'b0}}, rst_en, run};
        OFS_RAW:    rd_data = {{(DATA_W-1){1'b0}}, raw};
        OFS_MASKED: rd_data = {{(DATA_W-1){1'b0}}, raw & run};
        OFS_STALL:  rd_data = {{(DATA_W-1){1'b0}}, stall};
        OFS_LOCK:   rd_data = locked ? LOCKED_CODE : '0;
        default:    rd_data = '0;
      endcase
    end
  end

endmodule

// File: rtl/wdog_lockable.sv
module wdog_lockable
  import wdog_pkg::*;
#(
  parameter int                DATA_W = 32,
  parameter int                ADDR_W = 4,
  parameter logic [DATA_W-1:0] KEY    = 32'h1ACC_E55E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              dbg_halt,
  output logic              irq,
  output logic              rst_req
);

  localparam int HI_W = ADDR_W - OFS_W;

  logic              wr_mapped, rd_mapped;
  wdog_ofs_e         wr_ofs, rd_ofs;
  logic [DATA_W-1:0] reload_q, count_q;
  logic              run_q, rst_en_q, stall_q, locked_q;
  logic              reload_wr, run_start, expire, raw_q;
  logic              zero_load, clear_wr;

  generate
    if (HI_W > 0) begin : g_hi
      assign wr_mapped = (wr_addr[ADDR_W-1:OFS_W] == '0);
      assign rd_mapped = (rd_addr[ADDR_W-1:OFS_W] == '0);
    end else begin : g_flat
      assign wr_mapped = 1'b1;
      assign rd_mapped = 1'b1;
    end
  endgenerate

  assign wr_ofs    = wdog_ofs_e'(wr_addr[OFS_W-1:0]);
  assign rd_ofs    = wdog_ofs_e'(rd_addr[OFS_W-1:0]);
  assign zero_load = reload_wr && (wr_data == '0);
  assign clear_wr  = wr_en && wr_mapped && (wr_ofs == OFS_CLEAR) && wr_data[0];
  assign irq       = raw_q && run_q;

  wdog_cfg #(.DATA_W(DATA_W), .KEY(KEY)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mapped(wr_mapped),
    .wr_ofs(wr_ofs), .wr_data(wr_data), .reload_q(reload_q), .run_q(run_q),
    .rst_en_q(rst_en_q), .stall_q(stall_q), .locked_q(locked_q),
    .reload_wr(reload_wr), .run_start(run_start)
  );

  wdog_count #(.DATA_W(DATA_W)) u_count (
    .clk(clk), .rst_n(rst_n), .run(run_q), .stall(stall_q),
    .dbg_halt(dbg_halt), .reload(reload_q), .reload_wr(reload_wr),
    .run_start(run_start), .wr_data(wr_data), .count_q(count_q),
    .expire(expire)
  );

  wdog_status u_status (
    .clk(clk), .rst_n(rst_n), .expire(expire), .zero_load(zero_load),
    .clear_wr(clear_wr), .rst_en(rst_en_q), .raw_q(raw_q),
    .rst_req_q(rst_req)
  );

  wdog_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .rd_mapped(rd_mapped), .rd_ofs(rd_ofs), .reload(reload_q),
    .count(count_q), .run(run_q), .rst_en(rst_en_q), .raw(raw_q),
    .stall(stall_q), .locked(locked_q), .rd_data(rd_data)
  );

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dbg_halt,
  input logic              irq,
  input logic              rst_req,
  input logic              run,
  input logic              rst_en,
  input logic              stall,
  input logic              locked,
  input logic              raw,
  input logic              clear_wr,
  input logic              expire,
  input logic              reload_wr,
  input logic              ctrl_hit,
  input logic [DATA_W-1:0] reload,
  input logic [DATA_W-1:0] count
);

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> run); // R2

  AST_IRQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (run && raw)); // R4

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_wr && !expire && !reload_wr) |=> !raw); // R5

  AST_RSTREQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(raw) && $past(rst_en))); // R6

  AST_LOCK_HOLDS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(reload)); // R7

  AST_LOCK_HOLDS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && ctrl_hit) |=> ($stable(run) && $stable(rst_en))); // R7

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && stall && dbg_halt && !reload_wr) |=> $stable(count)); // R11

endmodule

bind wdog_lockable wdog_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt), .irq(irq),
  .rst_req(rst_req), .run(run_q), .rst_en(rst_en_q), .stall(stall_q),
  .locked(locked_q), .raw(raw_q), .clear_wr(clear_wr), .expire(expire),
  .reload_wr(reload_wr),
  .ctrl_hit(wr_en && wr_mapped && (wr_ofs == wdog_pkg::OFS_CTRL)),
  .reload(reload_q), .count(count_q)
);

// File: tb/tb_wdog_lockable.sv
`timescale 1ns/1ps
module tb_wdog_lockable;

  localparam logic [31:0] KEY = 32'h1ACC_E55E;
  localparam logic [3:0] A_RELOAD = 4'd0, A_COUNT = 4'd1, A_CTRL = 4'd2,
                         A_CLEAR = 4'd3, A_RAW = 4'd4, A_MASKED = 4'd5,
                         A_STALL = 4'd6, A_LOCK = 4'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        dbg_halt = 1'b0;
  logic        irq, rst_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdog_lockable dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .dbg_halt(dbg_halt), .irq(irq), .rst_req(rst_req)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    rd_addr = a;
    #0.1;
    v = rd_data;
  endtask

  task automatic chk_reg(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_addr = a;
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    dbg_halt = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] c0;
    @(negedge clk);
    do_reset;

    // R1 reset state
    chk_reg("R1 reload", A_RELOAD, 32'hFFFF_FFFF);
    chk_reg("R1 count",  A_COUNT,  32'hFFFF_FFFF);
    chk_reg("R1 ctrl",   A_CTRL,   32'h0);
    chk_reg("R1 raw",    A_RAW,    32'h0);
    chk_reg("R1 stall",  A_STALL,  32'h0);
    chk_reg("R1 lock",   A_LOCK,   32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 rst_req", {31'b0, rst_req}, 32'h0);

    // R3 R6 R5 sweep over reload values
    for (int l = 1; l <= 8; l++) begin
      do_reset;
      wr(A_RELOAD, 32'(l));
      wr(A_CTRL, 32'h3);
      chk_reg("R2 count after run", A_COUNT, 32'(l));
      chk_reg("R2 ctrl readback", A_CTRL, 32'h3);
      for (int k = 1; k <= l; k++) begin
        tick(1);
        chk_reg("R3 countdown", A_COUNT, 32'(l - k));
        chk_reg("R3 no early timeout", A_RAW, 32'h0);
      end
      tick(1);
      chk_reg("R3 timeout raw", A_RAW, 32'h1);
      chk_reg("R3 reload on expiry", A_COUNT, 32'(l));
      chk("R4 irq on timeout", {31'b0, irq}, 32'h1);
      chk("R6 no pulse first expiry", {31'b0, rst_req}, 32'h0);
      tick(l);
      chk("R6 no pulse before second", {31'b0, rst_req}, 32'h0);
      tick(1);
      chk("R6 pulse on second expiry", {31'b0, rst_req}, 32'h1);
      tick(1);
      chk("R6 pulse one cycle", {31'b0, rst_req}, 32'h0);
      wr(A_CLEAR, 32'h1);
      // with l==1 the clear edge is an expiry edge, which wins
      chk_reg("R5 clear raw", A_RAW, (l == 1) ? 32'h1 : 32'h0);
      chk_reg("R4 masked follows raw", A_MASKED, (l == 1) ? 32'h1 : 32'h0);
    end

    // R10 R4 zero reload while stopped
    do_reset;
    wr(A_RELOAD, 32'h0);
    chk_reg("R10 zero reload raw", A_RAW, 32'h1);
    chk_reg("R4 masked stopped", A_MASKED, 32'h0);
    chk("R4 irq stopped", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'h1);
    chk_reg("R4 masked running", A_MASKED, 32'h1);
    chk("R4 irq running", {31'b0, irq}, 32'h1);
    wr(A_CTRL, 32'h0);
    chk_reg("R2 run sticky", A_CTRL, 32'h1);

    // R9 reload write while running
    do_reset;
    wr(A_RELOAD, 32'd100);
    wr(A_CTRL, 32'h1);
    tick(5);
    chk_reg("R12 live count", A_COUNT, 32'd95);
    wr(A_RELOAD, 32'd40);
    chk_reg("R9 immediate copy", A_COUNT, 32'd40);
    tick(3);
    chk_reg("R9 runs from new value", A_COUNT, 32'd37);

    // R11 stall
    wr(A_STALL, 32'h1);
    chk_reg("R11 stall readback", A_STALL, 32'h1);
    dbg_halt = 1'b1;
    rd(A_COUNT, c0);
    tick(5);
    chk_reg("R11 frozen in halt", A_COUNT, c0);
    dbg_halt = 1'b0;
    tick(2);
    chk_reg("R11 resumes", A_COUNT, c0 - 32'd2);
    dbg_halt = 1'b1;
    wr(A_STALL, 32'h0);
    rd(A_COUNT, c0);
    tick(3);
    chk_reg("R11 no stall runs in halt", A_COUNT, c0 - 32'd3);
    dbg_halt = 1'b0;

    // R7 R8 lock
    wr(A_LOCK, 32'h0);
    chk_reg("R7 lock reads locked", A_LOCK, 32'h1);
    rd(A_COUNT, c0);
    wr(A_RELOAD, 32'd7);
    chk_reg("R7 reload ignored", A_RELOAD, 32'd40);
    chk_reg("R7 count untouched", A_COUNT, c0 - 32'd1);
    wr(A_STALL, 32'h1);
    chk_reg("R7 stall ignored", A_STALL, 32'h0);
    wr(A_CTRL, 32'h2);
    chk_reg("R7 ctrl ignored", A_CTRL, 32'h1);
    wr(A_LOCK, KEY ^ 32'h1);
    chk_reg("R7 near key still locks", A_LOCK, 32'h1);
    wr(A_LOCK, KEY);
    chk_reg("R8 unlocked", A_LOCK, 32'h0);
    wr(A_RELOAD, 32'd7);
    chk_reg("R8 reload writable", A_RELOAD, 32'd7);
    chk_reg("R8 count follows", A_COUNT, 32'd7);

    // R12 unmapped reads
    for (int a = 8; a < 16; a++)
      chk_reg("R12 unmapped zero", 4'(a), 32'h0);
    chk_reg("R12 clear offset reads zero", A_CLEAR, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule